// File: doc/BRIEF.md
# Three-Pin State Strobe Decoder

This block lets a host move a radio between its four main states (sleep, idle, receive, transmit) with only the chip-select, serial clock and serial data-in pins of an SPI port, without sending a byte. While chip-select is high, the host sets a two-bit command on the clock and data pins. When chip-select falls, the block latches those levels and turns them into one internal command strobe. After that, and until chip-select rises again, the pins belong to the SPI byte engine. That engine is outside this block, and the block tells it when it owns the pins.

All three pins pass through two-flop synchronizers into the core clock, and both edges of chip-select are found there. A receive or transmit strobe acts at once. The sleep strobe is held pending until chip-select rises again. The code 11 produces no strobe: it only brings a sleeping radio back to idle. The strobes drive a small state register, which is part of this block. A configuration enable gates the whole feature.

Top module: `tripin_strobe_ctrl`

## Requirements
- R1: While `feat_en` is low, a chip-select falling edge produces no strobe and leaves `radio_state` unchanged.
- R2: While chip-select stays high, changes on `sclk` and `sdi` produce no strobe and no state change.
- R3: On a synchronized chip-select falling edge with `feat_en` high, the code {sclk,sdi} is latched. Code 01 issues a strobe with `cmd_kind`=01 and sets `radio_state` to receive. Code 10 issues a strobe with `cmd_kind`=10 and sets `radio_state` to transmit. The `radio_state` encoding is 0 sleep, 1 idle, 2 receive, 3 transmit.
- R4: While chip-select is low, toggling `sclk` and `sdi` produces no further strobe.
- R5: A transmit strobe (kind 10) that arrives while `radio_state` is transmit is ignored, and the state stays transmit.
- R6: A receive strobe (kind 01) that arrives while `radio_state` is receive pulses `rx_restart` for one cycle, and the state stays receive.
- R7: Code 00 sets `sleep_pend` while chip-select is low and issues no strobe yet. The synchronized rising edge of chip-select then issues a strobe with `cmd_kind`=00, and `radio_state` becomes sleep.
- R8: Code 11 issues no strobe. It moves `radio_state` from sleep to idle and leaves any other state unchanged.
- R9: If `feat_en` goes low while a sleep strobe is pending, the pending strobe is cancelled: `sleep_pend` clears and no strobe follows when chip-select rises.
- R10: After reset, `radio_state` is idle, `sleep_pend` is 0, and `spi_owns` is 0. `spi_owns` is high while the synchronized chip-select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| feat_en | input | 1 | Enables pin command decoding |
| csn | input | 1 | Chip-select pin, active low, asynchronous |
| sclk | input | 1 | Serial clock pin, command bit 1 while chip-select is high |
| sdi | input | 1 | Serial data-in pin, command bit 0 while chip-select is high |
| spi_owns | output | 1 | High while the synchronized chip-select is low |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_kind | output | 2 | Code of the strobe: 00 sleep, 01 receive, 10 transmit |
| sleep_pend | output | 1 | A deferred sleep strobe is waiting for chip-select to rise |
| rx_restart | output | 1 | One-cycle pulse when a receive strobe restarts reception |
| radio_state | output | 2 | 0 sleep, 1 idle, 2 receive, 3 transmit |

## Verification
The case hardest to reach from the pins is cancelling a deferred sleep. The stimulus has to hold chip-select low long enough for `sleep_pend` to be seen set. It then drops `feat_en` inside that window, raises chip-select afterwards, and expects no strobe. In every command sequence the bench also toggles `sclk` and `sdi` while chip-select is low, and again while it is high with no edge. A scoreboard queue records each strobe the bench expects, so any extra strobe and any missing strobe both show up.

// File: rtl/tripin_pkg.sv
package tripin_pkg;
   typedef enum logic [1:0] {
      RS_SLEEP = 2'd0,
      RS_IDLE  = 2'd1,
      RS_RX    = 2'd2,
      RS_TX    = 2'd3
   } radio_st_t;

   localparam logic [1:0] CODE_SLEEP = 2'b00;
   localparam logic [1:0] CODE_RX    = 2'b01;
   localparam logic [1:0] CODE_TX    = 2'b10;
   localparam logic [1:0] CODE_WAKE  = 2'b11;
endpackage

// File: rtl/tripin_sync.sv
module tripin_sync #(
   parameter int             WIDTH   = 3,
   parameter int             STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tripin_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/tripin_edge.sv
module tripin_edge #(
   parameter logic IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic fall,
   output logic rise
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= IDLE_LEVEL;
      else        lvl_q <= lvl;
   end

   assign fall = lvl_q & ~lvl;
   assign rise = ~lvl_q & lvl;
endmodule

// File: rtl/tripin_decode.sv
module tripin_decode
   import tripin_pkg::*;
#(
   parameter bit SLEEP_DEFER = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       feat_en,
   input  logic       cs_fall,
   input  logic       cs_rise,
   input  logic [1:0] code,
   output logic       stb,
   output logic [1:0] kind,
   output logic       wake,
   output logic       pend
);
   logic       imm_stb;
   logic [1:0] imm_kind;
   logic       late_stb;

   always_comb begin
      imm_stb  = 1'b0;
      imm_kind = code;
      if (cs_fall && feat_en) begin
         unique case (code)
            CODE_RX, CODE_TX: imm_stb = 1'b1;
            CODE_SLEEP:       imm_stb = !SLEEP_DEFER;
            default:          imm_stb = 1'b0;
         endcase
      end
   end

   if (SLEEP_DEFER) begin : g_defer
      logic pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   pend_q <= 1'b0;
         else if (!feat_en)                            pend_q <= 1'b0;
         else if (cs_fall && code == CODE_SLEEP)       pend_q <= 1'b1;
         else if (cs_rise)                             pend_q <= 1'b0;
      end
      assign pend     = pend_q;
      assign late_stb = pend_q & cs_rise & feat_en;
   end else begin : g_immediate
      assign pend     = 1'b0;
      assign late_stb = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb  <= 1'b0;
         kind <= CODE_SLEEP;
         wake <= 1'b0;
      end else begin
         stb  <= imm_stb | late_stb;
         wake <= cs_fall & feat_en & (code == CODE_WAKE);
         if (late_stb)     kind <= CODE_SLEEP;
         else if (imm_stb) kind <= imm_kind;
      end
   end
endmodule

// File: rtl/tripin_state.sv
module tripin_state
   import tripin_pkg::*;
#(
   parameter radio_st_t RST_STATE = RS_IDLE
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stb,
   input  logic [1:0] kind,
   input  logic       wake,
   output radio_st_t  state,
   output logic       restart
);
   radio_st_t nxt;
   logic      nxt_restart;

   always_comb begin
      nxt         = state;
      nxt_restart = 1'b0;
      if (stb) begin
         unique case (kind)
            CODE_SLEEP: nxt = RS_SLEEP;
            CODE_RX: begin
               nxt         = RS_RX;
               nxt_restart = (state == RS_RX);
            end
            CODE_TX:    if (state != RS_TX) nxt = RS_TX;
            default:    nxt = state;
         endcase
      end else if (wake && state == RS_SLEEP) begin
         nxt = RS_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RST_STATE;
         restart <= 1'b0;
      end else begin
         state   <= nxt;
         restart <= nxt_restart;
      end
   end
endmodule

// File: rtl/tripin_strobe_ctrl.sv
module tripin_strobe_ctrl
   import tripin_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit SLEEP_DEFER = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       feat_en,
   input  logic       csn,
   input  logic       sclk,
   input  logic       sdi,
   output logic       spi_owns,
   output logic       cmd_stb,
   output logic [1:0] cmd_kind,
   output logic       sleep_pend,
   output logic       rx_restart,
   output logic [1:0] radio_state
);
   localparam int PINS = 3;
   localparam logic [PINS-1:0] PIN_RST = 3'b100;

   logic [PINS-1:0] pins_s;
   logic            cs_fall, cs_rise;
   logic            wake;
   radio_st_t       st;

   tripin_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({csn, sclk, sdi}),
      .dout (pins_s)
   );

   tripin_edge #(.IDLE_LEVEL(1'b1)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (pins_s[2]),
      .fall (cs_fall),
      .rise (cs_rise)
   );

   tripin_decode #(.SLEEP_DEFER(SLEEP_DEFER)) u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .feat_en(feat_en),
      .cs_fall(cs_fall),
      .cs_rise(cs_rise),
      .code   (pins_s[1:0]),
      .stb    (cmd_stb),
      .kind   (cmd_kind),
      .wake   (wake),
      .pend   (sleep_pend)
   );

   tripin_state #(.RST_STATE(RS_IDLE)) u_state (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (cmd_stb),
      .kind   (cmd_kind),
      .wake   (wake),
      .state  (st),
      .restart(rx_restart)
   );

   assign spi_owns    = ~pins_s[2];
   assign radio_state = st;
endmodule

// File: rtl/tripin_checks.sv
module tripin_checks (
   input logic       clk,
   input logic       rst_n,
   input logic       feat_en,
   input logic       spi_owns,
   input logic       cmd_stb,
   input logic [1:0] cmd_kind,
   input logic       sleep_pend,
   input logic       rx_restart,
   input logic [1:0] radio_state
);
   // R1: a strobe is only issued while the feature was enabled
   a_r1_stb_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb |-> $past(feat_en));

   // R3 / R4: receive and transmit strobes only right after chip-select fell
   a_r4_only_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb && cmd_kind != 2'b00) |-> ($past(spi_owns) && !$past(spi_owns, 2)));

   // R5: transmit while transmitting keeps the state
   a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb && cmd_kind == 2'b10 && radio_state == 2'd3) |=> radio_state == 2'd3);

   // R6: a restart pulse only occurs in receive
   a_r6_restart_in_rx: assert property (@(posedge clk) disable iff (!rst_n)
      rx_restart |-> (radio_state == 2'd2 && $past(radio_state) == 2'd2));

   // R7: the sleep strobe comes after chip-select has gone high
   a_r7_sleep_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb && cmd_kind == 2'b00) |-> !$past(spi_owns));

   // R8: leaving sleep without a strobe goes to idle
   a_r8_wake_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(radio_state) == 2'd0 && radio_state != 2'd0 && !$past(cmd_stb)) |-> radio_state == 2'd1);

   // R9: disabling clears a pending sleep
   a_r9_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      !feat_en |=> !sleep_pend);
endmodule

bind tripin_strobe_ctrl tripin_checks u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .feat_en    (feat_en),
   .spi_owns   (spi_owns),
   .cmd_stb    (cmd_stb),
   .cmd_kind   (cmd_kind),
   .sleep_pend (sleep_pend),
   .rx_restart (rx_restart),
   .radio_state(radio_state)
);

// File: tb/sim_tripin_strobe_ctrl.sv
`timescale 1ns/1ps
module sim_tripin_strobe_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       feat_en = 1'b0;
   logic       csn = 1'b1;
   logic       sclk = 1'b0;
   logic       sdi = 1'b0;
   logic       spi_owns, cmd_stb, sleep_pend, rx_restart;
   logic [1:0] cmd_kind, radio_state;

   int checks = 0;
   int errors = 0;
   int restarts = 0;
   bit done = 1'b0;
   logic [1:0] exp_q[$];

   always #5 clk = ~clk;

   tripin_strobe_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .csn(csn), .sclk(sclk), .sdi(sdi),
      .spi_owns(spi_owns), .cmd_stb(cmd_stb), .cmd_kind(cmd_kind),
      .sleep_pend(sleep_pend), .rx_restart(rx_restart), .radio_state(radio_state)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Monitor: compares each strobe against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n && cmd_stb) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R1/R2/R4/R9 unexpected strobe", int'(cmd_kind), -1);
         end else begin
            logic [1:0] e;
            e = exp_q.pop_front();
            check(cmd_kind == e, "R3/R7 strobe kind", int'(cmd_kind), int'(e));
         end
      end
      if (rst_n && rx_restart) restarts++;
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic spi_noise();
      for (int i = 0; i < 6; i++) begin
         sclk = ~sclk; sdi = (i % 3 == 0); cycles(1);
      end
   endtask

   // Driver: one pin command with SPI traffic during the low phase
   task automatic pin_cmd(input logic [1:0] code, input bit expect_stb);
      sclk = code[1]; sdi = code[0];
      cycles(4);
      if (expect_stb) exp_q.push_back(code);
      csn = 1'b0;
      cycles(6);
      spi_noise();
      csn = 1'b1;
      cycles(8);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         check(1'b0, "watchdog", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      cycles(3);
      rst_n = 1'b1;
      cycles(2);
      // R10 reset state
      check(radio_state == 2'd1, "R10 reset state", radio_state, 1);
      check(!sleep_pend, "R10 reset pend", sleep_pend, 0);
      check(!spi_owns, "R10 reset spi_owns", spi_owns, 0);

      // R1: disabled
      pin_cmd(2'b01, 1'b0);
      check(radio_state == 2'd1, "R1 disabled no change", radio_state, 1);
      feat_en = 1'b1;

      // R2: pins move while csn high
      for (int i = 0; i < 4; i++) begin sclk = i[0]; sdi = i[1]; cycles(3); end
      check(radio_state == 2'd1, "R2 csn high no effect", radio_state, 1);

      // R3: receive
      pin_cmd(2'b01, 1'b1);
      check(radio_state == 2'd2, "R3 rx state", radio_state, 2);
      check(restarts == 0, "R6 no restart from idle", restarts, 0);
      // R6: receive again
      pin_cmd(2'b01, 1'b1);
      check(radio_state == 2'd2, "R6 still rx", radio_state, 2);
      check(restarts == 1, "R6 restart pulse", restarts, 1);
      // R3: transmit, R5 repeat
      pin_cmd(2'b10, 1'b1);
      check(radio_state == 2'd3, "R3 tx state", radio_state, 3);
      pin_cmd(2'b10, 1'b1);
      check(radio_state == 2'd3, "R5 tx ignored", radio_state, 3);
      check(restarts == 1, "R5 no restart", restarts, 1);

      // R4: spi_owns while low, R7: deferred sleep
      sclk = 1'b0; sdi = 1'b0; cycles(4);
      exp_q.push_back(2'b00);
      csn = 1'b0; cycles(6);
      check(spi_owns, "R10 spi_owns low phase", spi_owns, 1);
      check(sleep_pend, "R7 pend set", sleep_pend, 1);
      spi_noise();
      check(radio_state == 2'd3, "R7 not yet asleep", radio_state, 3);
      check(exp_q.size() == 1, "R7 strobe held", exp_q.size(), 1);
      csn = 1'b1; cycles(8);
      check(radio_state == 2'd0, "R7 asleep after rise", radio_state, 0);
      check(!sleep_pend, "R7 pend cleared", sleep_pend, 0);

      // R8: wake
      pin_cmd(2'b11, 1'b0);
      check(radio_state == 2'd1, "R8 wake to idle", radio_state, 1);
      pin_cmd(2'b01, 1'b1);
      pin_cmd(2'b11, 1'b0);
      check(radio_state == 2'd2, "R8 no effect in rx", radio_state, 2);

      // R9: cancel
      sclk = 1'b0; sdi = 1'b0; cycles(4);
      csn = 1'b0; cycles(6);
      check(sleep_pend, "R9 pend before cancel", sleep_pend, 1);
      feat_en = 1'b0; cycles(3);
      check(!sleep_pend, "R9 pend cancelled", sleep_pend, 0);
      feat_en = 1'b1; cycles(2);
      csn = 1'b1; cycles(8);
      check(radio_state == 2'd2, "R9 no sleep", radio_state, 2);

      // sleep then receive directly
      pin_cmd(2'b00, 1'b1);
      check(radio_state == 2'd0, "R7 sleep again", radio_state, 0);
      pin_cmd(2'b01, 1'b1);
      check(radio_state == 2'd2, "R3 rx from sleep", radio_state, 2);

      check(exp_q.size() == 0, "R3/R7 all strobes seen", exp_q.size(), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule